// File: doc/BRIEF.md
# Packet Receive Queue with Register Read-Out

This block takes packets arriving on an AXI4-Stream style input and holds them until a host collects them through a small register window. Every accepted beat is written to a word store. When the beat carrying `s_tlast` is accepted, the packet's word count goes into a separate length queue. Packet boundaries therefore never have to be found again inside the word store.

The host follows a fixed order. It polls the occupancy register until that register is nonzero. It then reads the length register, which hands over the oldest complete packet and returns its size in bytes. It then reads the data register once per word. Reads that break this order do not touch the stored data. They set their own sticky flag in a status register and return zero: a length read in the middle of a packet, a data read past the end of the packet, and a data read with nothing stored. Writing the flush key to the reset register empties the whole receive side.

Top module: `pkt_rx_fifo`

## Requirements
- R1: After the synchronous reset, `s_tready` is 1, `reg_rdata` is 0, and the status, occupancy and length registers all read 0.
- R2: A beat is accepted on a clock edge where `s_tvalid` and `s_tready` are both high. `s_tready` is low while the word store holds DEPTH words or the length queue holds PKTS packets, and returns high once a read frees a slot.
- R3: A read at offset 0x1C returns the number of stored words not yet popped. Words of a packet whose last beat has not yet arrived are included.
- R4: A read at offset 0x24 returns 4 times the word count of the oldest complete packet and makes it the current packet. If no complete packet is queued, the read returns 0 and nothing changes.
- R5: A read at offset 0x20 while the current packet has words left returns the next word in arrival order and pops it.
- R6: A read at offset 0x20 when the current packet is used up but words are stored sets status bit 30 (over-read). It returns 0 and pops nothing.
- R7: A read at offset 0x20 with the word store empty sets status bit 29 (empty read) and returns 0.
- R8: A read at offset 0x24 while the current packet still has words left sets status bit 31 (under-read) and returns 0. The remaining words stay readable.
- R9: Status bit 26 (packet complete) is set on the edge that accepts a beat with `s_tlast` high.
- R10: Writing 0xA5 to offset 0x18 discards all stored words, all queued lengths and the packet being received, and sets status bit 23 (flush done). Any other value written there has no effect.
- R11: A read at offset 0x00 returns the status register. A write to offset 0x00 clears every status bit whose `reg_wdata` bit is 1. A flag raised in the same cycle takes precedence over the clear.
- R12: Read data appears on `reg_rdata` in the cycle after the read strobe and holds until the next read. An unmapped offset reads 0. If `reg_wr` and `reg_rd` are both high, the read has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | DATA_W | Stream data beat |
| s_tvalid | input | 1 | Stream beat valid |
| s_tlast | input | 1 | Last beat of a packet |
| s_tready | output | 1 | Block can accept a beat |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, valid the cycle after a read |

## Verification
Every register read result is due in the cycle after its strobe edge. Every status flag is due on that same edge. The bench drives each strobe on a falling edge and reads `reg_rdata` on the next falling edge, half a cycle after the edge that produced it. `s_tready` depends only on state registered at the previous edge. The stream driver samples it on the falling edge before a beat's rising edge, so it knows exactly which beats were taken. Flags and occupancy are checked with separate reads after the stimulus that should have changed them, and never in the cycle of that stimulus.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
  localparam int OFF_STATUS = 'h00;
  localparam int OFF_FLUSH  = 'h18;
  localparam int OFF_OCC    = 'h1C;
  localparam int OFF_DATA   = 'h20;
  localparam int OFF_LEN    = 'h24;

  localparam int FLUSH_KEY  = 'hA5;

  localparam int FLG_UNDER  = 31;
  localparam int FLG_OVER   = 30;
  localparam int FLG_EMPTY  = 29;
  localparam int FLG_DONE   = 26;
  localparam int FLG_FLUSH  = 23;

  typedef enum logic {
    SEL_HOLD = 1'b0,
    SEL_WORD = 1'b1
  } rd_sel_e;
endpackage

// File: rtl/rx_sync_fifo.sv
module rx_sync_fifo #(
  parameter int WIDTH      = 32,
  parameter int DEPTH      = 64,
  parameter bit SHOW_AHEAD = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flush,
  input  logic                        push,
  input  logic [WIDTH-1:0]            din,
  input  logic                        pop,
  output logic [WIDTH-1:0]            dout,
  output logic [$clog2(DEPTH+1)-1:0]  count,
  output logic                        full,
  output logic                        empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  generate
    if (SHOW_AHEAD) begin : g_ahead
      assign dout = mem[rd_ptr];
    end else begin : g_reg
      logic [WIDTH-1:0] dout_q;
      always_ff @(posedge clk) begin
        if (do_pop) dout_q <= mem[rd_ptr];
      end
      assign dout = dout_q;
    end
  endgenerate
endmodule

// File: rtl/rx_stream_in.sv
module rx_stream_in #(
  parameter int DEPTH = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flush,
  input  logic                        s_tvalid,
  input  logic                        s_tlast,
  input  logic                        word_full,
  input  logic                        len_full,
  output logic                        s_tready,
  output logic                        word_push,
  output logic                        len_push,
  output logic [$clog2(DEPTH+1)-1:0]  len_val,
  output logic                        last_acc
);
  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0] beat_cnt;
  logic          acc;

  assign s_tready  = !word_full && !len_full;
  assign acc       = s_tvalid && s_tready;
  assign word_push = acc;
  assign len_push  = acc && s_tlast;
  assign last_acc  = acc && s_tlast && !flush;
  assign len_val   = beat_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      beat_cnt <= '0;
    end else if (acc) begin
      beat_cnt <= s_tlast ? '0 : beat_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rx_host_port.sv
module rx_host_port
  import pkt_rx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reg_wr,
  input  logic                        reg_rd,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  input  logic [$clog2(DEPTH+1)-1:0]  occ,
  input  logic                        word_empty,
  input  logic [DATA_W-1:0]           word_dout,
  input  logic [$clog2(DEPTH+1)-1:0]  len_head,
  input  logic                        len_empty,
  input  logic                        last_acc,
  output logic                        flush,
  output logic                        word_pop,
  output logic                        len_pop,
  output logic [$clog2(DEPTH+1)-1:0]  remaining,
  output logic [31:0]                 status,
  output logic [DATA_W-1:0]           reg_rdata
);
  localparam int CW    = $clog2(DEPTH+1);
  localparam int SHIFT = $clog2(DATA_W/8);

  logic              rd, rd_len, rd_data, wr_clr;
  logic              len_ok, under_rd, data_ok, empty_rd, over_rd;
  logic [31:0]       set_mask, clr_mask;
  logic [DATA_W-1:0] hold_q, hold_d;
  rd_sel_e           sel_q;

  assign flush   = reg_wr && (reg_addr == ADDR_W'(OFF_FLUSH))
                   && (reg_wdata == DATA_W'(FLUSH_KEY));
  assign wr_clr  = reg_wr && (reg_addr == ADDR_W'(OFF_STATUS));
  assign rd      = reg_rd && !reg_wr;
  assign rd_len  = rd && (reg_addr == ADDR_W'(OFF_LEN));
  assign rd_data = rd && (reg_addr == ADDR_W'(OFF_DATA));

  assign len_ok   = rd_len && (remaining == '0) && !len_empty;
  assign under_rd = rd_len && (remaining != '0);
  assign data_ok  = rd_data && (remaining != '0);
  assign empty_rd = rd_data && (remaining == '0) && word_empty;
  assign over_rd  = rd_data && (remaining == '0) && !word_empty;

  assign len_pop  = len_ok;
  assign word_pop = data_ok;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      remaining <= '0;
    end else if (len_ok) begin
      remaining <= len_head;
    end else if (data_ok) begin
      remaining <= remaining - 1'b1;
    end
  end

  always_comb begin
    set_mask = '0;
    set_mask[FLG_UNDER] = under_rd;
    set_mask[FLG_OVER]  = over_rd;
    set_mask[FLG_EMPTY] = empty_rd;
    set_mask[FLG_DONE]  = last_acc;
    set_mask[FLG_FLUSH] = flush;
    clr_mask = wr_clr ? reg_wdata[31:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr_mask) | set_mask;
  end

  always_comb begin
    hold_d = '0;
    if (reg_addr == ADDR_W'(OFF_STATUS)) begin
      hold_d = DATA_W'(status);
    end else if (reg_addr == ADDR_W'(OFF_OCC)) begin
      hold_d = DATA_W'(occ);
    end else if (len_ok) begin
      hold_d = DATA_W'({len_head, {SHIFT{1'b0}}});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      sel_q  <= SEL_HOLD;
    end else if (rd) begin
      hold_q <= hold_d;
      sel_q  <= data_ok ? SEL_WORD : SEL_HOLD;
    end
  end

  assign reg_rdata = (sel_q == SEL_WORD) ? word_dout : hold_q;
endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int PKTS   = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tvalid,
  input  logic              s_tlast,
  output logic              s_tready,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int CW  = $clog2(DEPTH+1);
  localparam int LCW = $clog2(PKTS+1);

  logic              flush_w;
  logic              word_push, word_pop, word_full, word_empty;
  logic [DATA_W-1:0] word_dout;
  logic [CW-1:0]     occ_w;
  logic              len_push, len_pop, len_full, len_empty;
  logic [CW-1:0]     len_val, len_head;
  logic [LCW-1:0]    len_cnt_w;
  logic              last_acc;
  logic [CW-1:0]     rem_w;
  logic [31:0]       status_w;

  rx_stream_in #(.DEPTH(DEPTH)) u_in (
    .clk(clk), .rst(rst), .flush(flush_w),
    .s_tvalid(s_tvalid), .s_tlast(s_tlast),
    .word_full(word_full), .len_full(len_full),
    .s_tready(s_tready), .word_push(word_push),
    .len_push(len_push), .len_val(len_val), .last_acc(last_acc)
  );

  rx_sync_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH), .SHOW_AHEAD(1'b0)) u_words (
    .clk(clk), .rst(rst), .flush(flush_w),
    .push(word_push), .din(s_tdata), .pop(word_pop),
    .dout(word_dout), .count(occ_w), .full(word_full), .empty(word_empty)
  );

  rx_sync_fifo #(.WIDTH(CW), .DEPTH(PKTS), .SHOW_AHEAD(1'b1)) u_lens (
    .clk(clk), .rst(rst), .flush(flush_w),
    .push(len_push), .din(len_val), .pop(len_pop),
    .dout(len_head), .count(len_cnt_w), .full(len_full), .empty(len_empty)
  );

  rx_host_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_host (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .occ(occ_w), .word_empty(word_empty), .word_dout(word_dout),
    .len_head(len_head), .len_empty(len_empty), .last_acc(last_acc),
    .flush(flush_w), .word_pop(word_pop), .len_pop(len_pop),
    .remaining(rem_w), .status(status_w), .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/pkt_rx_chk.sv
module pkt_rx_chk
  import pkt_rx_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int PKTS   = 8,
  parameter int CW     = 7,
  parameter int LCW    = 4,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              s_tvalid,
  input logic              s_tready,
  input logic              s_tlast,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              flush,
  input logic [CW-1:0]     occ,
  input logic [LCW-1:0]    len_cnt,
  input logic [CW-1:0]     remaining,
  input logic [31:0]       status
);
  assert_ready_words_R2: assert property (@(posedge clk) disable iff (rst)
    (occ == CW'(DEPTH)) |-> !s_tready);

  assert_ready_pkts_R2: assert property (@(posedge clk) disable iff (rst)
    (len_cnt == LCW'(PKTS)) |-> !s_tready);

  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));

  assert_occ_step_R3: assert property (@(posedge clk) disable iff (rst)
    !flush |=> (32'(occ) <= 32'($past(occ)) + 1));

  assert_rem_bound_R5: assert property (@(posedge clk) disable iff (rst)
    remaining <= occ);

  assert_empty_read_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_wr && reg_addr == ADDR_W'(OFF_DATA) && occ == '0)
    |=> status[FLG_EMPTY]);

  assert_under_read_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_wr && reg_addr == ADDR_W'(OFF_LEN) && remaining != '0)
    |=> (status[FLG_UNDER] && remaining == $past(remaining)));

  assert_done_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (s_tvalid && s_tready && s_tlast && !flush) |=> status[FLG_DONE]);

  assert_flush_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (status[FLG_FLUSH] && occ == '0 && remaining == '0));
endmodule

bind pkt_rx_fifo pkt_rx_chk #(
  .DEPTH(DEPTH), .PKTS(PKTS), .CW(CW), .LCW(LCW), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .s_tvalid(s_tvalid), .s_tready(s_tready),
  .s_tlast(s_tlast), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .flush(flush_w), .occ(occ_w), .len_cnt(len_cnt_w),
  .remaining(rem_w), .status(status_w)
);

// File: tb/tb_pkt_rx_fifo.sv
module tb_pkt_rx_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int PKTS       = 8;
  localparam int NPKT       = 30;
  localparam int WATCHDOG   = 100000;

  localparam logic [5:0] A_STAT = 6'h00, A_FLUSH = 6'h18, A_OCC = 6'h1C,
                         A_DATA = 6'h20, A_LEN = 6'h24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] s_tdata = '0;
  logic        s_tvalid = 1'b0, s_tlast = 1'b0, s_tready;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_words[$];
  int          exp_lens[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_rx_fifo #(.DATA_W(32), .DEPTH(DEPTH), .PKTS(PKTS), .ADDR_W(6)) dut (
    .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
    .s_tlast(s_tlast), .s_tready(s_tready), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send_beat(input logic [31:0] d, input logic l, input int gapmax);
    logic r;
    s_tvalid = 1'b0;
    repeat ($urandom_range(0, gapmax)) @(negedge clk);
    s_tvalid = 1'b1; s_tdata = d; s_tlast = l;
    do begin
      r = s_tready;
      @(posedge clk); @(negedge clk);
    end while (!r);
    s_tvalid = 1'b0; s_tlast = 1'b0;
  endtask

  task automatic sender();
    for (int p = 0; p < NPKT; p++) begin
      int n;
      logic [31:0] w[16];
      n = $urandom_range(1, 16);
      for (int k = 0; k < n; k++) begin
        w[k] = $urandom;
        exp_words.push_back(w[k]);
      end
      exp_lens.push_back(n);
      for (int k = 0; k < n; k++) send_beat(w[k], k == n-1, 3);
    end
  endtask

  task automatic reader();
    int got = 0;
    logic [31:0] v;
    while (got < NPKT) begin
      reg_read(A_OCC, v);
      if (v == 0) continue;
      reg_read(A_LEN, v);
      if (v == 0) continue;
      if (exp_lens.size() == 0) begin
        chk("R4 unexpected packet", v, 32'd0);
        got = NPKT;
      end else begin
        int e;
        e = exp_lens.pop_front();
        chk("R4 random length", v, 32'(e * 4));
        for (int k = 0; k < e; k++) begin
          reg_read(A_DATA, v);
          chk("R5 random data", v, exp_words.pop_front());
        end
        got++;
      end
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] v, keep;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk("R1 ready", 32'(s_tready), 32'd1);
    chk("R1 rdata", reg_rdata, 32'd0);
    reg_read(A_STAT, v); chk("R1 status", v, 32'd0);
    reg_read(A_OCC, v);  chk("R1 occupancy", v, 32'd0);
    reg_read(A_LEN, v);  chk("R4 no packet length", v, 32'd0);

    // one three-word packet
    send_beat(32'hA000_0000, 1'b0, 0);
    send_beat(32'hA000_0001, 1'b0, 0);
    send_beat(32'hA000_0002, 1'b1, 0);
    reg_read(A_OCC, v);  chk("R3 occupancy", v, 32'd3);
    reg_read(A_STAT, v); chk("R9 complete flag", v, 32'h0400_0000);
    reg_write(A_STAT, 32'h0400_0000);
    reg_read(A_STAT, v); chk("R11 clear", v, 32'd0);

    // over-read before length
    reg_read(A_DATA, v); chk("R6 over-read data", v, 32'd0);
    reg_read(A_STAT, v); chk("R6 over-read flag", v, 32'h4000_0000);
    reg_read(A_OCC, v);  chk("R6 nothing popped", v, 32'd3);

    reg_read(A_LEN, v);  chk("R4 length", v, 32'd12);
    reg_read(A_DATA, v); chk("R5 word0", v, 32'hA000_0000);
    reg_read(A_LEN, v);  chk("R8 under-read data", v, 32'd0);
    reg_read(A_STAT, v); chk("R8 under-read flag", v, 32'hC000_0000);
    reg_read(A_DATA, v); chk("R8 word1 kept", v, 32'hA000_0001);
    reg_read(A_DATA, v); chk("R5 word2", v, 32'hA000_0002);
    keep = v;
    @(negedge clk);
    chk("R12 rdata holds", reg_rdata, keep);
    reg_read(A_DATA, v); chk("R7 empty data", v, 32'd0);
    reg_read(A_STAT, v); chk("R7 empty flag", v, 32'hE000_0000);
    reg_write(A_STAT, 32'hFFFF_FFFF);

    // partial packet and flush
    send_beat(32'hB000_0000, 1'b0, 2);
    send_beat(32'hB000_0001, 1'b0, 2);
    reg_read(A_OCC, v);  chk("R3 partial occupancy", v, 32'd2);
    reg_read(A_LEN, v);  chk("R4 partial length", v, 32'd0);
    reg_write(A_FLUSH, 32'h5A);
    reg_read(A_OCC, v);  chk("R10 wrong key ignored", v, 32'd2);
    reg_write(A_FLUSH, 32'hA5);
    reg_read(A_OCC, v);  chk("R10 flushed", v, 32'd0);
    reg_read(A_STAT, v); chk("R10 flush flag", v, 32'h0080_0000);
    reg_write(A_STAT, 32'hFFFF_FFFF);

    // word store full
    for (int k = 0; k < DEPTH; k++) send_beat(32'hC000_0000 + 32'(k), 1'b0, 0);
    chk("R2 ready low when words full", 32'(s_tready), 32'd0);
    reg_read(A_OCC, v);  chk("R3 full occupancy", v, 32'(DEPTH));
    reg_write(A_FLUSH, 32'hA5);
    chk("R2 ready after flush", 32'(s_tready), 32'd1);

    // length queue full
    for (int k = 0; k < PKTS; k++) send_beat(32'hD000_0000 + 32'(k), 1'b1, 1);
    chk("R2 ready low when lengths full", 32'(s_tready), 32'd0);
    reg_read(A_LEN, v);  chk("R4 single length", v, 32'd4);
    reg_read(A_DATA, v); chk("R5 single word", v, 32'hD000_0000);
    chk("R2 ready after drain", 32'(s_tready), 32'd1);
    reg_write(A_FLUSH, 32'hA5);
    reg_write(A_STAT, 32'hFFFF_FFFF);

    reg_read(6'h04, v);  chk("R12 unmapped", v, 32'd0);

    fork
      sender();
      reader();
    join
    reg_read(A_OCC, v);  chk("R3 drained", v, 32'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule